// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Client

This block is the target side of a two-wire serial bus (I2C style) in front of a byte-wide storage array. It oversamples the bus clock and the open-drain data line with the system clock, finds Start and Stop conditions, and answers only to a device address whose three low selection bits equal three strap inputs. Up to eight such blocks can therefore share one bus.

The host writes by sending the device address, two address bytes and then data. Data bytes go into a 64-byte page buffer, and the page is committed to the array when the host sends Stop. The block then stays busy for a programmable number of clock cycles. While it is busy it ignores its address, so a host can poll until it answers. Reads return bytes from an internal address pointer. The pointer is loaded by a dummy write (random read) or left where the last access ended (current-address read). It advances across the whole array, so reads can be sequential. A write-protect input refuses data bytes and prevents any commit. The array is a behavioural register file of 2^AW bytes: AW is 15 for the full 32,768 bytes and is smaller by default.

Top module: `eeprom_i2c_client`

## Requirements
- R1: The block acknowledges a device address byte only when bits 7..4 are 1010 and bits 3..1 equal `strap_i[2:0]`. Bit 0 selects read (1) or write (0). With any other address the data line stays released until the next Start.
- R2: Bytes travel most significant bit first. On the ninth clock of each byte the receiving side acknowledges by holding the data line low.
- R3: The data line is sampled while the bus clock rises. The block changes what it drives only after a falling bus clock edge, or when a Start or Stop is detected.
- R4: A Start (data falling while the clock is high) aborts any partial byte and begins a new device address phase. A write interrupted this way commits nothing.
- R5: A write carries a high address byte (its bits above the array width are ignored), a low address byte and 1 to 64 data bytes. After Stop only the received locations change.
- R6: During a write, the low 6 bits of the address increment after each data byte and wrap within the same 64-byte page.
- R7: While `wp_i` is high, data bytes are not acknowledged and the array is not changed by the Stop that follows. No busy period starts.
- R8: For `WR_CYCLES` clock cycles after a committed write, device address bytes are not acknowledged.
- R9: A random read (write address, dummy address bytes, repeated Start, read address) returns the byte stored at the given location.
- R10: Each byte read advances the pointer across the full array, rolling from the last location to 0. A read started without address bytes continues from the pointer.
- R11: A read ends when the host answers a byte with no-acknowledge. The block then releases the data line.
- R12: After reset the data line is released, the pointer is 0 and the array reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock from the host |
| sda_i | input | 1 | Sensed level of the open-drain data line |
| strap_i | input | 3 | Device selection straps compared with address bits 3..1 |
| wp_i | input | 1 | Write protect: high refuses data bytes and commits |
| sda_oe_o | output | 1 | High pulls the data line low |

## Verification
The assertions assume that the bus clock holds each level for several system clocks, so that every edge is seen once after synchronisation. They also assume that the host changes the data line only while the clock is low, except for Start and Stop. The bench drives the bus with an 8-cycle half period. It moves data in the middle of the low phase and samples in the middle of the high phase. It releases the line whenever the block may drive it, so the bus line models open-drain wiring.

// File: rtl/eepi2c_pkg.sv
package eepi2c_pkg;
    localparam logic [3:0] DEV_TYPE   = 4'b1010;
    localparam int         PAGE_AW    = 6;
    localparam int         PAGE_BYTES = 1 << PAGE_AW;

    typedef enum logic [2:0] {
        ST_IDLE, ST_DEV, ST_AHI, ST_ALO, ST_WR, ST_RD
    } phase_e;

    typedef struct packed {
        logic sda;
        logic rise;
        logic fall;
        logic start;
        logic stop;
    } bus_ev_t;

    function automatic logic dev_hit(input logic [7:0] b, input logic [2:0] strap);
        return (b[7:4] == DEV_TYPE) && (b[3:1] == strap);
    endfunction
endpackage

// File: rtl/eepi2c_bus_sense.sv
module eepi2c_bus_sense
    import eepi2c_pkg::*;
#(
    parameter int SYNC = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev_o
);
    logic [SYNC-1:0] scl_sy, sda_sy;
    logic            scl_p, sda_p;
    logic            scl_n, sda_n;

    assign scl_n = scl_sy[SYNC-1];
    assign sda_n = sda_sy[SYNC-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sy <= '1;
            sda_sy <= '1;
            scl_p  <= 1'b1;
            sda_p  <= 1'b1;
        end else begin
            scl_sy <= {scl_sy[SYNC-2:0], scl_i};
            sda_sy <= {sda_sy[SYNC-2:0], sda_i};
            scl_p  <= scl_n;
            sda_p  <= sda_n;
        end
    end

    always_comb begin
        ev_o.sda   = sda_n;
        ev_o.rise  = scl_n & ~scl_p;
        ev_o.fall  = ~scl_n & scl_p;
        ev_o.start = scl_n & scl_p & sda_p & ~sda_n;
        ev_o.stop  = scl_n & scl_p & ~sda_p & sda_n;
    end

    AST_ONE_EVENT: assert property (@(posedge clk) disable iff (rst)
        $countones({ev_o.rise, ev_o.fall, ev_o.start, ev_o.stop}) <= 1) // R4
        else $error("bus events overlap");
endmodule

// File: rtl/eepi2c_store.sv
module eepi2c_store
    import eepi2c_pkg::*;
#(
    parameter int AW        = 10,
    parameter int WR_CYCLES = 5000
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wp_i,
    input  logic                  buf_we,
    input  logic                  buf_clr,
    input  logic [PAGE_AW-1:0]    buf_idx,
    input  logic [7:0]            buf_din,
    input  logic                  commit_i,
    input  logic [AW-PAGE_AW-1:0] page_i,
    input  logic [AW-1:0]         rd_addr,
    output logic [7:0]            rd_data,
    output logic                  busy_o
);
    localparam int DEPTH = 1 << AW;
    localparam int CW    = $clog2(WR_CYCLES + 1);

    logic [7:0]            mem  [DEPTH];
    logic [7:0]            pbuf [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] vld;
    logic [CW-1:0]         cnt;
    logic                  do_commit;

    assign do_commit = commit_i && (|vld);
    assign rd_data   = mem[rd_addr];
    assign busy_o    = (cnt != '0);

    always_ff @(posedge clk) begin
        if (buf_we) pbuf[buf_idx] <= buf_din;
    end

    always_ff @(posedge clk) begin
        if (rst || buf_clr || do_commit) vld <= '0;
        else if (buf_we)                 vld[buf_idx] <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
        end else if (do_commit) begin
            for (int i = 0; i < PAGE_BYTES; i++)
                if (vld[i]) mem[{page_i, PAGE_AW'(i)}] <= pbuf[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)            cnt <= '0;
        else if (do_commit) cnt <= CW'(WR_CYCLES);
        else if (busy_o)    cnt <= cnt - 1'b1;
    end

    AST_WP_NO_BUSY: assert property (@(posedge clk) disable iff (rst)
        (wp_i && !busy_o) |=> !busy_o) // R7
        else $error("busy started while protected");
    AST_NO_COMMIT_BUSY: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> !commit_i) // R8
        else $error("commit during busy period");
endmodule

// File: rtl/eeprom_i2c_client.sv
module eeprom_i2c_client
    import eepi2c_pkg::*;
#(
    parameter int AW        = 10,
    parameter int WR_CYCLES = 5000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] strap_i,
    input  logic       wp_i,
    output logic       sda_oe_o
);
    bus_ev_t       ev;
    phase_e        st;
    logic [3:0]    bitcnt;
    logic [7:0]    rx, tx, rd_data;
    logic          acked, host_nack, sda_oe, busy, ack_now;
    logic [AW-9:0] ahi;
    logic [AW-1:0] ptr, ptr_inc, rd_addr;
    logic          buf_we, buf_clr, commit;

    assign ptr_inc  = ptr + 1'b1;
    assign rd_addr  = (st == ST_RD) ? ptr_inc : ptr;
    assign buf_we   = ev.fall && (st == ST_WR) && (bitcnt == 4'd8) && !wp_i;
    assign buf_clr  = ev.fall && (st == ST_ALO) && (bitcnt == 4'd8);
    assign commit   = ev.stop && (st == ST_WR) && !wp_i;
    assign sda_oe_o = sda_oe;

    eepi2c_bus_sense #(.SYNC(2)) u_sense (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .ev_o(ev)
    );

    eepi2c_store #(.AW(AW), .WR_CYCLES(WR_CYCLES)) u_store (
        .clk(clk), .rst(rst), .wp_i(wp_i),
        .buf_we(buf_we), .buf_clr(buf_clr), .buf_idx(ptr[PAGE_AW-1:0]), .buf_din(rx),
        .commit_i(commit), .page_i(ptr[AW-1:PAGE_AW]),
        .rd_addr(rd_addr), .rd_data(rd_data), .busy_o(busy)
    );

    always_comb begin
        unique case (st)
            ST_DEV:         ack_now = dev_hit(rx, strap_i) && !busy;
            ST_AHI, ST_ALO: ack_now = 1'b1;
            ST_WR:          ack_now = !wp_i;
            default:        ack_now = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= ST_IDLE; bitcnt <= '0; rx <= '0; tx <= '0;
            acked <= 1'b0; host_nack <= 1'b1; sda_oe <= 1'b0;
            ahi <= '0; ptr <= '0;
        end else if (ev.start) begin
            st <= ST_DEV; bitcnt <= '0; acked <= 1'b0; sda_oe <= 1'b0;
        end else if (ev.stop) begin
            st <= ST_IDLE; bitcnt <= '0; sda_oe <= 1'b0;
        end else if (st != ST_IDLE) begin
            if (ev.rise) begin
                if (bitcnt < 4'd8)       rx <= {rx[6:0], ev.sda};
                else if (bitcnt == 4'd8) host_nack <= ev.sda;
                if (bitcnt < 4'd9)       bitcnt <= bitcnt + 1'b1;
            end else if (ev.fall) begin
                if (st == ST_RD) begin
                    if (bitcnt == 4'd8) begin
                        sda_oe <= 1'b0;
                    end else if (bitcnt == 4'd9) begin
                        ptr    <= ptr_inc;
                        bitcnt <= '0;
                        if (!host_nack) begin
                            tx     <= rd_data;
                            sda_oe <= ~rd_data[7];
                        end else begin
                            st     <= ST_IDLE;
                            sda_oe <= 1'b0;
                        end
                    end else if (bitcnt != 4'd0) begin
                        sda_oe <= ~tx[~bitcnt[2:0]];
                    end
                end else if (bitcnt == 4'd8) begin
                    acked  <= ack_now;
                    sda_oe <= ack_now;
                    if (st == ST_AHI) ahi <= rx[AW-9:0];
                    if (st == ST_ALO) ptr <= {ahi, rx};
                    if (st == ST_WR && ack_now)
                        ptr[PAGE_AW-1:0] <= ptr[PAGE_AW-1:0] + 1'b1;
                end else if (bitcnt == 4'd9) begin
                    sda_oe <= 1'b0;
                    bitcnt <= '0;
                    if (!acked) begin
                        st <= ST_IDLE;
                    end else begin
                        unique case (st)
                            ST_DEV: if (rx[0]) begin
                                        st     <= ST_RD;
                                        tx     <= rd_data;
                                        sda_oe <= ~rd_data[7];
                                    end else begin
                                        st <= ST_AHI;
                                    end
                            ST_AHI: st <= ST_ALO;
                            ST_ALO: st <= ST_WR;
                            default: st <= st;
                        endcase
                    end
                end
            end
        end
    end

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE) |-> !sda_oe) // R11
        else $error("line driven while idle");
    AST_ACK_SLOT: assert property (@(posedge clk) disable iff (rst)
        (sda_oe && st != ST_RD) |-> (bitcnt == 4'd8 || bitcnt == 4'd9)) // R2
        else $error("acknowledge outside ninth clock");
    AST_DRIVE_AFTER_FALL: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> $past(ev.fall || ev.start || ev.stop)) // R3
        else $error("output changed without falling clock");
    AST_BUSY_NACK: assert property (@(posedge clk) disable iff (rst)
        (ev.fall && st == ST_DEV && bitcnt == 4'd8 && busy) |=> !sda_oe) // R8
        else $error("address acknowledged while busy");
    AST_WP_NO_ACK: assert property (@(posedge clk) disable iff (rst)
        (ev.fall && st == ST_WR && bitcnt == 4'd8 && wp_i) |=> !sda_oe) // R7
        else $error("data acknowledged while protected");
endmodule

// File: tb/sim_eeprom_i2c_client.sv
module sim_eeprom_i2c_client;
    localparam int AW    = 10;
    localparam int DEPTH = 1 << AW;
    localparam int WRC   = 400;
    localparam int H     = 8;
    localparam logic [2:0] STRAP = 3'b101;
    localparam logic [7:0] DEV_W = {4'b1010, STRAP, 1'b0};
    localparam logic [7:0] DEV_R = {4'b1010, STRAP, 1'b1};

    logic clk = 1'b0, rst = 1'b1, scl = 1'b1, hlow = 1'b0, wp = 1'b0;
    logic sda_oe, sda_bus;
    assign sda_bus = ~(hlow | sda_oe);

    eeprom_i2c_client #(.AW(AW), .WR_CYCLES(WRC)) u0 (
        .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_bus),
        .strap_i(STRAP), .wp_i(wp), .sda_oe_o(sda_oe)
    );

    always #10 clk = ~clk;

    typedef struct { logic [7:0] v; string tag; } exp_t;
    exp_t       exp_q[$];
    logic [7:0] obs_q[$];
    logic [7:0] model [DEPTH];
    logic [7:0] wq[$];
    int checks = 0, errors = 0;

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    initial begin : monitor
        forever begin
            wait (obs_q.size() > 0);
            if (exp_q.size() == 0) chk("scoreboard-empty", obs_q[0], 0);
            else begin
                chk(exp_q[0].tag, obs_q[0], exp_q[0].v);
                void'(exp_q.pop_front());
            end
            void'(obs_q.pop_front());
        end
    end

    task automatic tick(int n); repeat (n) @(negedge clk); endtask

    task automatic bstart;
        hlow = 1'b0; tick(H/2); scl = 1'b1; tick(H); hlow = 1'b1; tick(H); scl = 1'b0; tick(H/2);
    endtask
    task automatic bstop;
        hlow = 1'b1; tick(H/2); scl = 1'b1; tick(H); hlow = 1'b0; tick(H);
    endtask
    task automatic bit_out(logic b);
        hlow = ~b; tick(H/2); scl = 1'b1; tick(H); scl = 1'b0; tick(H/2);
    endtask
    task automatic bit_in(output logic b);
        hlow = 1'b0; tick(H/2); scl = 1'b1; tick(H/2); b = sda_bus; tick(H/2); scl = 1'b0; tick(H/2);
    endtask
    task automatic wbyte(logic [7:0] v, output logic ack);
        logic a;
        for (int i = 7; i >= 0; i--) bit_out(v[i]);
        bit_in(a);
        ack = ~a;
    endtask
    task automatic rbyte(logic last);
        logic [7:0] v;
        for (int i = 7; i >= 0; i--) bit_in(v[i]);
        bit_out(last);
        obs_q.push_back(v);
    endtask

    task automatic send_addr(int addr, string tag);
        logic a;
        wbyte(DEV_W, a);                  chk({tag, " dev ack"}, a, 1);
        wbyte({1'b1, 7'(addr >> 8)}, a);  chk({tag, " hi ack"}, a, 1);
        wbyte(8'(addr), a);               chk({tag, " lo ack"}, a, 1);
    endtask

    task automatic write_seq(int addr, string tag);
        logic a;
        bstart;
        send_addr(addr, tag);
        for (int i = 0; i < wq.size(); i++) begin
            wbyte(wq[i], a);
            chk({tag, " R2 data ack"}, a, wp ? 0 : 1);
            if (!wp) model[{addr[9:6], 6'(addr + i)}] = wq[i];
        end
        bstop;
    endtask

    task automatic wait_ready(string tag);
        logic a;
        int polls = 0;
        do begin
            bstart; wbyte(DEV_W, a); bstop; polls++;
        end while (!a && polls < 50);
        chk({tag, " R8 first poll refused"}, (polls > 1) ? 1 : 0, 1);
    endtask

    task automatic read_tail(int addr, int n, string tag);
        logic a;
        wbyte(DEV_R, a); chk({tag, " R1 read addr ack"}, a, 1);
        for (int i = 0; i < n; i++) begin
            exp_q.push_back('{model[(addr + i) % DEPTH], tag});
            rbyte(i == n - 1);
        end
        chk({tag, " R11 released after NACK"}, sda_bus, 1);
        bstop;
        wait (obs_q.size() == 0);
    endtask

    task automatic rand_read(int addr, int n, string tag);
        bstart; send_addr(addr, tag); bstart; read_tail(addr, n, tag);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : driver
        logic a;
        for (int i = 0; i < DEPTH; i++) model[i] = 8'h00;
        tick(5); rst = 1'b0; tick(5);
        chk("R12 line released after reset", sda_bus, 1);
        // R12 pointer 0: current-address read of location 0
        bstart; read_tail(0, 1, "R12 pointer");

        // R1 wrong straps: no acknowledge
        bstart; wbyte({4'b1010, 3'b000, 1'b0}, a); chk("R1 mismatch nack", a, 0);
        wbyte(8'h00, a); chk("R1 ignored byte", a, 0); bstop;

        // R5 byte write then R9 random read
        wq = '{8'h3C}; write_seq(12'h005, "R5 byte");
        wait_ready("R5 byte");
        rand_read(12'h005, 1, "R9 random");

        // R5 partial page, R10 sequential read around it
        wq = '{8'h11, 8'h22, 8'h33}; write_seq(12'h081, "R5 partial");
        wait_ready("R5 partial");
        rand_read(12'h07F, 6, "R5 R10 seq");

        // R6 wrap inside page 0x0C0..0x0FF
        wq = '{8'hA1, 8'hB2, 8'hC3, 8'hD4}; write_seq(12'h0FE, "R6 wrap");
        wait_ready("R6 wrap");
        rand_read(12'h0C0, 3, "R6 wrapped bytes");
        rand_read(12'h0FE, 1, "R6 page end");
        // R10 current-address continues at 0x0FF
        bstart; read_tail(12'h0FF, 1, "R10 current");

        // R10 rollover from last location to 0
        wq = '{8'h9E, 8'h9F}; write_seq(DEPTH - 2, "R10 top");
        wait_ready("R10 top");
        wq = '{8'h5A}; write_seq(0, "R10 zero");
        wait_ready("R10 zero");
        rand_read(DEPTH - 2, 3, "R10 rollover");

        // R7 write protect
        wp = 1'b1;
        wq = '{8'hEE}; write_seq(12'h005, "R7 protect");
        bstart; wbyte(DEV_W, a); chk("R7 no busy after protected write", a, 1); bstop;
        wp = 1'b0;
        rand_read(12'h005, 1, "R7 unchanged");

        // R4 Start inside a data byte aborts the write
        bstart; send_addr(12'h005, "R4 abort");
        bit_out(1'b1); bit_out(1'b1); bit_out(1'b0);
        bstart; read_tail(12'h005, 1, "R4 no commit");
        bstart; wbyte(DEV_W, a); chk("R4 not busy", a, 1); bstop;

        // R3 sampling: alternating pattern through the full path
        wq = '{8'h96, 8'h69}; write_seq(12'h200, "R3 pattern");
        wait_ready("R3 pattern");
        rand_read(12'h200, 2, "R3 R2 msb first");

        tick(20);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule